// File: doc/BRIEF.md
# Chroma Pair-Lane Reformatter and Formatter

This block sits between narrow two-bit colour-difference buses and a shared eight-bit chroma processing path. On the receive side, the U and V streams each arrive two bits per clock. Four clocks carry one full two's-complement sample per component, so one U and one V sample arrive for every four luminance clocks. The block assembles each sample, most significant pair first, and hands the pair of samples to a single time-multiplexed path: U first, with its own strobe, then V on the next clock with a second strobe.

On the send side, processed U and V samples come back over one shared eight-bit bus. Separate load strobes capture them, and the block splits them back into two-bit pairs in the same order. A return write-enable marks the line, which arrives one line later from the line store. The block also forwards the write-enable to its output. A single phase-select bit moves the write-enable on both sides by exactly one clock relative to the sample data. When the bit is clear, the enable is aligned with the data. When it is set, the enable leads the data by one clock.

Top module: `chromaFmtTop`

## Requirements
- R1: While `rstN` is low, `muxUStb`, `muxVStb`, `muxData`, `uOut`, `vOut` and `weOut` are all zero (with `weRet` low).
- R2: An assembled sample takes `uIn`/`vIn` bits 7:6 on the first clock of a group, then bits 5:4, 3:2 and 1:0 on the following three clocks. The eight-bit two's-complement value is passed on unchanged.
- R3: The U sample appears on `muxData` with `muxUStb` high in the clock after the last clock of its group. The V sample follows with `muxVStb` high in the next clock. The two strobes are never high together.
- R4: A group restarts at every rising edge of the effective input write-enable. A group cut short by the enable falling produces no strobe, and it does not shift the groups of the following line.
- R5: With `phaseSel` = 0, the first data clock of a line is the clock in which `weIn` is first high. With `phaseSel` = 1, it is the clock after that.
- R6: `retUStb` loads `retData` as the next U sample to send, and `retVStb` loads it as the next V sample. Each load takes effect at the start of the next output group.
- R7: When `weRet` rises in clock s, bits 7:6 of the loaded samples appear on `uOut`/`vOut` in clock s+1, followed by 5:4, 3:2 and 1:0. Groups repeat every four clocks while `weRet` stays high.
- R8: With `phaseSel` = 0, `weOut` equals `weRet` delayed by one clock, which aligns it with the output pairs. With `phaseSel` = 1, `weOut` follows `weRet` in the same clock, one clock ahead of the pairs.
- R9: While `weRet` is low, `uOut` and `vOut` keep their last value, even when new return samples are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseSel | input | 1 | Write-enable phase: 0 aligned with data, 1 one clock ahead |
| weIn | input | 1 | Input line write-enable |
| uIn | input | 2 | U bit pair per clock |
| vIn | input | 2 | V bit pair per clock |
| muxData | output | 8 | Multiplexed chroma sample to the shared path |
| muxUStb | output | 1 | `muxData` holds a U sample |
| muxVStb | output | 1 | `muxData` holds a V sample |
| retData | input | 8 | Processed chroma sample from the shared path |
| retUStb | input | 1 | Load `retData` as the next U sample to send |
| retVStb | input | 1 | Load `retData` as the next V sample to send |
| weRet | input | 1 | Data-aligned write-enable of the delayed output line |
| uOut | output | 2 | U bit pair per clock |
| vOut | output | 2 | V bit pair per clock |
| weOut | output | 1 | Output write-enable, phase set by `phaseSel` |

## Verification
Four properties are checked on every cycle: the U and V strobes never overlap, V always follows U, every completed input group produces a U strobe, and the output pairs stay still while `weRet` is low. The aligned phase of `weOut` is also checked on every cycle. Bit order, the exact clock on which each strobe appears, the one-clock data shift set by `phaseSel`, the discarding of a short group and the contents of the serialised output can only be shown by the bench's scenarios. Those scenarios sweep all 256 sample values in both phase modes.

// File: rtl/chromaFmtPkg.sv
package chromaFmtPkg;
  // Strobes handed from the phase control to the datapath
  typedef struct packed {
    logic inShift;    // a pair is present on the input lanes
    logic inLast;     // this pair completes an input group
    logic outActive;  // the output line is running
    logic outFirst;   // first clock of an output group
  } fmtCtl_t;
endpackage

// File: rtl/chromaFmtCtl.sv
module chromaFmtCtl
  import chromaFmtPkg::*;
#(
  parameter int GROUP_LEN = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    phaseSel,
  input  logic    weIn,
  input  logic    weRet,
  output fmtCtl_t ctl,
  output logic    weOut
);
  localparam int PH_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(GROUP_LEN - 1);

  logic weInD, weRetD, weEff;
  logic [1:0] actVec;
  logic [1:0] firstVec;
  logic [1:0] lastVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weInD  <= 1'b0;
      weRetD <= 1'b0;
    end else begin
      weInD  <= weIn;
      weRetD <= weRet;
    end
  end

  // With phaseSel set, the enable leads the data by one clock on both sides
  assign weEff  = phaseSel ? weInD : weIn;
  assign weOut  = phaseSel ? weRet : weRetD;
  assign actVec = {weRet, weEff};

  // Lane 0 tracks input groups, lane 1 tracks output groups
  for (genvar k = 0; k < 2; k++) begin : gPhase
    logic actD;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] ph;
    logic rise;

    assign rise = actVec[k] && !actD;
    assign ph   = rise ? '0 : cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actD <= 1'b0;
        cnt  <= '0;
      end else begin
        actD <= actVec[k];
        if (!actVec[k] || ph == LAST_PH) cnt <= '0;
        else                             cnt <= ph + PH_W'(1);
      end
    end

    assign firstVec[k] = actVec[k] && (ph == '0);
    assign lastVec[k]  = actVec[k] && (ph == LAST_PH);
  end

  assign ctl.inShift   = actVec[0];
  assign ctl.inLast    = lastVec[0];
  assign ctl.outActive = actVec[1];
  assign ctl.outFirst  = firstVec[1];

  // R4
  group_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inLast |-> $past(ctl.inShift));

  // R8
  we_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.outFirst && !phaseSel) |=> (weOut || phaseSel));
endmodule

// File: rtl/chromaFmtDp.sv
module chromaFmtDp
  import chromaFmtPkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LANE_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmtCtl_t             ctl,
  input  logic [LANE_W-1:0]   uIn,
  input  logic [LANE_W-1:0]   vIn,
  output logic [SAMPLE_W-1:0] muxData,
  output logic                muxUStb,
  output logic                muxVStb,
  input  logic [SAMPLE_W-1:0] retData,
  input  logic                retUStb,
  input  logic                retVStb,
  output logic [LANE_W-1:0]   uOut,
  output logic [LANE_W-1:0]   vOut
);
  localparam int ASM_W = SAMPLE_W - LANE_W;

  // Lane 0 carries U, lane 1 carries V
  logic [LANE_W-1:0]   laneIn  [2];
  logic [LANE_W-1:0]   laneOut [2];
  logic [SAMPLE_W-1:0] full    [2];
  logic [1:0]          retStb;
  logic [SAMPLE_W-1:0] grpV;

  assign laneIn[0] = uIn;
  assign laneIn[1] = vIn;
  assign uOut      = laneOut[0];
  assign vOut      = laneOut[1];
  assign retStb    = {retVStb, retUStb};

  for (genvar k = 0; k < 2; k++) begin : gLane
    logic [ASM_W-1:0]    asmReg;
    logic [SAMPLE_W-1:0] holdReg;
    logic [SAMPLE_W-1:0] actReg;

    assign full[k] = {asmReg, laneIn[k]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        asmReg     <= '0;
        holdReg    <= '0;
        actReg     <= '0;
        laneOut[k] <= '0;
      end else begin
        if (ctl.inShift) asmReg <= full[k][ASM_W-1:0];
        if (retStb[k])   holdReg <= retData;
        if (ctl.outFirst) begin
          laneOut[k] <= holdReg[SAMPLE_W-1 -: LANE_W];
          actReg     <= holdReg << LANE_W;
        end else if (ctl.outActive) begin
          laneOut[k] <= actReg[SAMPLE_W-1 -: LANE_W];
          actReg     <= actReg << LANE_W;
        end
      end
    end
  end

  // Shared path: U in the clock after the group, V in the clock after that
  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxData <= '0;
      muxUStb <= 1'b0;
      muxVStb <= 1'b0;
      grpV    <= '0;
    end else begin
      muxUStb <= ctl.inLast;
      muxVStb <= muxUStb;
      if (ctl.inLast) begin
        muxData <= full[0];
        grpV    <= full[1];
      end else if (muxUStb) begin
        muxData <= grpV;
      end
    end
  end

  // R3
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(muxUStb && muxVStb));

  // R3
  v_follows_u_chk: assert property (@(posedge clk) disable iff (!rstN)
    muxUStb |=> muxVStb);

  // R3
  u_after_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inLast |=> muxUStb);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.outActive |=> ($stable(uOut) && $stable(vOut)));
endmodule

// File: rtl/chromaFmtTop.sv
module chromaFmtTop
  import chromaFmtPkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LANE_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                phaseSel,
  input  logic                weIn,
  input  logic [LANE_W-1:0]   uIn,
  input  logic [LANE_W-1:0]   vIn,
  output logic [SAMPLE_W-1:0] muxData,
  output logic                muxUStb,
  output logic                muxVStb,
  input  logic [SAMPLE_W-1:0] retData,
  input  logic                retUStb,
  input  logic                retVStb,
  input  logic                weRet,
  output logic [LANE_W-1:0]   uOut,
  output logic [LANE_W-1:0]   vOut,
  output logic                weOut
);
  localparam int GROUP_LEN = SAMPLE_W / LANE_W;

  fmtCtl_t ctl;

  chromaFmtCtl #(.GROUP_LEN(GROUP_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .phaseSel(phaseSel), .weIn(weIn),
    .weRet(weRet), .ctl(ctl), .weOut(weOut)
  );

  chromaFmtDp #(.SAMPLE_W(SAMPLE_W), .LANE_W(LANE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .uIn(uIn), .vIn(vIn),
    .muxData(muxData), .muxUStb(muxUStb), .muxVStb(muxVStb),
    .retData(retData), .retUStb(retUStb), .retVStb(retVStb),
    .uOut(uOut), .vOut(vOut)
  );
endmodule

// File: tb/sim_chromaFmtTop.sv
`timescale 1ns/1ps
module sim_chromaFmtTop;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, phaseSel, weIn, retUStb, retVStb, weRet;
  logic [1:0] uIn, vIn, uOut, vOut;
  logic [7:0] muxData, retData;
  logic muxUStb, muxVStb, weOut;

  chromaFmtTop u0 (
    .clk(clk), .rstN(rstN), .phaseSel(phaseSel), .weIn(weIn), .uIn(uIn), .vIn(vIn),
    .muxData(muxData), .muxUStb(muxUStb), .muxVStb(muxVStb),
    .retData(retData), .retUStb(retUStb), .retVStb(retVStb),
    .weRet(weRet), .uOut(uOut), .vOut(vOut), .weOut(weOut)
  );

  int passCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit doneFlag = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] uVal(input int g); return 8'(g); endfunction
  function automatic logic [7:0] vVal(input int g); return 8'(g * 37 + 11); endfunction
  function automatic logic [1:0] pairOf(input logic [7:0] v, input int p);
    return 2'(v >> (6 - 2 * p));
  endfunction

  // Monitor of the shared-path strobes
  logic [7:0] expU [256];
  logic [7:0] expV [256];
  int nU = 0, nV = 0, dataStart = 0;
  bit monOn = 0;
  always @(negedge clk) begin
    if (monOn) begin
      if (muxUStb) begin
        chk(muxData == expU[nU & 255], "R2 U sample", muxData, expU[nU & 255]);
        chk(cyc == dataStart + 4 * nU + 4, "R3 U strobe clock", cyc, dataStart + 4 * nU + 4);
        nU++;
      end
      if (muxVStb) begin
        chk(muxData == expV[nV & 255], "R2 V sample", muxData, expV[nV & 255]);
        chk(cyc == dataStart + 4 * nV + 5, "R3 V strobe clock", cyc, dataStart + 4 * nV + 5);
        nV++;
      end
    end
  end

  // Drive n groups; data shifted by ps clocks after the enable (R5)
  task automatic sendLine(input int n, input bit ps, input int offset);
    for (int g = 0; g < n; g++) begin
      expU[g] = uVal(g + offset);
      expV[g] = vVal(g + offset);
    end
    nU = 0; nV = 0;
    for (int i = 0; i < 4 * n + 1; i++) begin
      int idx;
      @(negedge clk);
      weIn = (i < 4 * n);
      idx = i - int'(ps);
      if (idx == 0) dataStart = cyc;
      if (idx >= 0 && idx < 4 * n) begin
        uIn = pairOf(uVal(idx / 4 + offset), idx % 4);
        vIn = pairOf(vVal(idx / 4 + offset), idx % 4);
      end else begin
        uIn = 2'b11; vIn = 2'b11;
      end
    end
    repeat (4) @(negedge clk);
    chk(nU == n, ps ? "R5 U count" : "R3 U count", nU, n);
    chk(nV == n, ps ? "R5 V count" : "R3 V count", nV, n);
  endtask

  // Serialise n groups on the output side, reloading samples mid-group
  task automatic outLine(input int n, input bit ps);
    logic prevWe;
    @(negedge clk); retData = uVal(0); retUStb = 1;
    @(negedge clk); retUStb = 0; retData = vVal(0); retVStb = 1;
    @(negedge clk); retVStb = 0;
    prevWe = 0;
    for (int i = 0; i < 4 * n + 1; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        int g = (i - 1) / 4;
        int p = (i - 1) % 4;
        chk(uOut == pairOf(uVal(g), p), "R7 uOut pair", uOut, pairOf(uVal(g), p));
        chk(vOut == pairOf(vVal(g), p), "R7 vOut pair", vOut, pairOf(vVal(g), p));
      end
      weRet = (i < 4 * n);
      retUStb = (i < 4 * n) && (i % 4 == 1);
      retVStb = (i < 4 * n) && (i % 4 == 2);
      if (retUStb) retData = uVal(i / 4 + 1);
      if (retVStb) retData = vVal(i / 4 + 1);
      #1;
      chk(weOut == (ps ? weRet : prevWe), "R8 weOut phase", weOut, ps ? weRet : prevWe);
      prevWe = weRet;
    end
    // R9: idle with fresh loads, pairs must hold
    @(negedge clk); retData = 8'h00; retUStb = 1; retVStb = 1;
    @(negedge clk); retUStb = 0; retVStb = 0;
    repeat (3) @(negedge clk);
    chk(uOut == pairOf(uVal(n - 1), 3), "R9 uOut hold", uOut, pairOf(uVal(n - 1), 3));
    chk(vOut == pairOf(vVal(n - 1), 3), "R9 vOut hold", vOut, pairOf(vVal(n - 1), 3));
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    failCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    rstN = 0; phaseSel = 0; weIn = 0; uIn = 0; vIn = 0;
    retData = 0; retUStb = 0; retVStb = 0; weRet = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(muxUStb == 0, "R1 muxUStb", muxUStb, 0);
    chk(muxVStb == 0, "R1 muxVStb", muxVStb, 0);
    chk(muxData == 0, "R1 muxData", muxData, 0);
    chk(uOut == 0 && vOut == 0, "R1 lane outputs", {uOut, vOut}, 0);
    chk(weOut == 0, "R1 weOut", weOut, 0);
    rstN = 1;
    @(negedge clk);
    monOn = 1;

    // R2, R3: all U values, aligned enable
    phaseSel = 0;
    sendLine(256, 0, 0);
    // R5: enable one clock ahead of data
    phaseSel = 1;
    sendLine(256, 1, 7);

    // R4: short group, then a fresh line must stay aligned
    phaseSel = 0;
    nU = 0; nV = 0;
    @(negedge clk); weIn = 1; uIn = 2'b01; vIn = 2'b10;
    @(negedge clk); uIn = 2'b11;
    @(negedge clk); weIn = 0;
    repeat (4) @(negedge clk);
    chk(nU == 0, "R4 short group U strobe", nU, 0);
    chk(nV == 0, "R4 short group V strobe", nV, 0);
    sendLine(3, 0, 100);

    monOn = 0;
    // R6, R7, R8, R9 on the output side in both phases
    phaseSel = 0;
    outLine(256, 0);
    phaseSel = 1;
    outLine(256, 1);

    finishRun();
  end
endmodule